// File: doc/BRIEF.md
# Receive Destination Address Filter

This block sits on the receive byte stream of an Ethernet MAC and decides, per frame, whether the frame is kept or discarded. The decision depends only on the destination address, which is the first six bytes of the frame. Four match sources can pass a frame:

- two programmable unicast addresses;
- the all-ones broadcast address;
- a 64-entry single-hash Bloom table for group addresses.

Each source has its own enable bit. Frames too short to carry a header are always discarded.

Bytes arrive one per beat, marked by valid, start and end flags. The destination bytes are gathered and their 6-bit hash is folded in as they arrive. One cycle after the end beat, a one-cycle decision strobe carries the accept bit. A narrow write port loads the addresses, the table and the enables. The configuration a frame is judged by is the one that was loaded before its start beat.

Top module: `rx_da_filter`

## Requirements
- R1: After reset, dec_valid and dec_accept are 0. All configuration is zero, so every frame is dropped until the filter is programmed.
- R2: A write with wr_en=1 loads one register, chosen by wr_sel:
  - 0: control. Bit 0 enables unicast 0, bit 1 enables unicast 1, bit 2 enables hashing of individual addresses, bit 3 enables broadcast.
  - 1: table bits 31:0.
  - 2: table bits 63:32.
  - 3: unicast 0 low word.
  - 4: unicast 0 high word.
  - 5: unicast 1 low word.
  - 6: unicast 1 high word.
  
  A low word holds destination bytes 0..3 in bits 7:0, 15:8, 23:16 and 31:24. A high word holds bytes 4 and 5 in bits 7:0 and 15:8.
- R3: When control bit 0 is set, a frame whose six destination bytes equal unicast address 0 is accepted. A single differing bit, or a cleared enable, does not match.
- R4: When control bit 1 is set, a frame whose destination equals unicast address 1 is accepted.
- R5: When control bit 3 is set, a frame whose destination is all ones is accepted.
- R6: The hash index is the XOR of the eight 6-bit slices of the 48-bit destination, where byte 0 occupies bits 7:0 and byte 5 occupies bits 47:40. The frame matches when table bit [index] is set. Indices 0..31 select bits of the low table word; indices 32..63 select bit (index-32) of the high word.
- R7: The hash lookup applies only when bit 0 of destination byte 0 is 1 (a group address), unless control bit 2 is set.
- R8: A frame of fewer than 12 bytes is dropped whatever its address. A 12-byte frame is judged normally.
- R9: dec_valid is 1 for exactly the one cycle after the end beat. dec_accept is 1 only in that cycle, and only for an accepted frame.
- R10: Configuration is captured at the start beat. A write made during a frame, or in the same cycle as its start beat, affects only later frames.
- R11: Cycles with in_valid=0 are ignored whatever the other stream inputs carry. An end beat that arrives outside a frame produces no decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select |
| wr_data | input | 32 | Register write data |
| in_valid | input | 1 | Stream beat valid |
| in_sop | input | 1 | First byte of a frame |
| in_eop | input | 1 | Last byte of a frame |
| in_data | input | 8 | Stream byte |
| dec_valid | output | 1 | Decision strobe, one cycle after the end beat |
| dec_accept | output | 1 | Frame accepted (meaningful while dec_valid is 1) |

## Verification
Any wrong internal state shows at the ports on the decision strobe of the frame it affects. A byte stored in the wrong slot, or a wrong shift of the hash fold, turns an expected accept into a drop, or the reverse, on the first frame that exercises it. A snapshot taken at the wrong moment shows up on the first frame that overlaps a register write. A stale byte count shows up on the next short frame. The sweep drives one address per hash index, against both a one-hot table and its complement. A single miswired index, or a mix-up between the table words, therefore fails within one frame.

// File: rtl/rx_filt_pkg.sv
package rx_filt_pkg;
  localparam int ADDR_BYTES = 6;
  localparam int ADDR_W     = 8 * ADDR_BYTES;
  localparam int HASH_W     = 6;
  localparam int TAB_W      = 2 ** HASH_W;

  typedef struct packed {
    logic [ADDR_W-1:0] ua0;
    logic [ADDR_W-1:0] ua1;
    logic [TAB_W-1:0]  gtab;
    logic              en_bcast;
    logic              en_indiv;
    logic              en_ua1;
    logic              en_ua0;
  } filt_cfg_t;

  // Contribution of byte k to the slice XOR: bit (8k+j) lands on hash bit (8k+j) mod HASH_W.
  function automatic logic [HASH_W-1:0] fold_byte(input logic [7:0] b, input int k);
    logic [HASH_W-1:0] h;
    h = '0;
    for (int j = 0; j < 8; j++) h[(8 * k + j) % HASH_W] ^= b[j];
    return h;
  endfunction
endpackage

// File: rtl/rx_filt_cfg.sv
module rx_filt_cfg
  import rx_filt_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic [2:0]  wr_sel,
  input  logic [31:0] wr_data,
  input  logic        sop_beat,
  output filt_cfg_t   act
);
  filt_cfg_t live;

  always_ff @(posedge clk) begin
    if (rst) begin
      live <= '0;
    end else if (wr_en) begin
      case (wr_sel)
        3'd0: {live.en_bcast, live.en_indiv, live.en_ua1, live.en_ua0} <= wr_data[3:0];
        3'd1: live.gtab[31:0]  <= wr_data;
        3'd2: live.gtab[63:32] <= wr_data;
        3'd3: live.ua0[31:0]   <= wr_data;
        3'd4: live.ua0[47:32]  <= wr_data[15:0];
        3'd5: live.ua1[31:0]   <= wr_data;
        3'd6: live.ua1[47:32]  <= wr_data[15:0];
        default: ;
      endcase
    end
  end

  // Frame-local copy: only a start beat refreshes it.
  always_ff @(posedge clk) begin
    if (rst)           act <= '0;
    else if (sop_beat) act <= live;
  end

  // R10
  cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !sop_beat |=> $stable(act));
endmodule

// File: rtl/rx_filt_parse.sv
module rx_filt_parse
  import rx_filt_pkg::*;
#(
  parameter int MIN_LEN = 12,
  localparam int CNT_W  = $clog2(MIN_LEN + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              in_sop,
  input  logic              in_eop,
  input  logic [7:0]        in_data,
  output logic              sop_beat,
  output logic              last_beat,
  output logic              len_ok,
  output logic [ADDR_W-1:0] da,
  output logic [HASH_W-1:0] hidx
);
  logic             in_frame;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] idx;
  logic             take;

  assign sop_beat  = in_valid && in_sop;
  assign take      = in_valid && (in_sop || in_frame);
  assign idx       = in_sop ? '0 : cnt;
  assign last_beat = take && in_eop;
  assign len_ok    = (int'(idx) + 1) >= MIN_LEN;

  always_ff @(posedge clk) begin
    if (rst) begin
      in_frame <= 1'b0;
      cnt      <= '0;
      da       <= '0;
      hidx     <= '0;
    end else if (take) begin
      in_frame <= !in_eop;
      cnt      <= (idx == CNT_W'(MIN_LEN)) ? idx : idx + 1'b1;
      for (int b = 0; b < ADDR_BYTES; b++)
        if (idx == CNT_W'(b)) da[8*b +: 8] <= in_data;
      hidx <= (in_sop ? '0 : hidx) ^
              ((idx < CNT_W'(ADDR_BYTES)) ? fold_byte(in_data, int'(idx)) : '0);
    end
  end

  // R8
  cnt_sat_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_W'(MIN_LEN));
endmodule

// File: rtl/rx_filt_decide.sv
module rx_filt_decide
  import rx_filt_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  filt_cfg_t         cfg,
  input  logic              last_beat,
  input  logic              len_ok,
  input  logic [ADDR_W-1:0] da,
  input  logic [HASH_W-1:0] hidx,
  output logic              dec_valid,
  output logic              dec_accept
);
  logic hit_ua0, hit_ua1, hit_bc, hit_grp, hit_any;

  always_comb begin
    hit_ua0 = cfg.en_ua0 && (da == cfg.ua0);
    hit_ua1 = cfg.en_ua1 && (da == cfg.ua1);
    hit_bc  = cfg.en_bcast && (&da);
    hit_grp = (da[0] || cfg.en_indiv) && cfg.gtab[hidx];
    hit_any = hit_ua0 || hit_ua1 || hit_bc || hit_grp;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dec_valid  <= 1'b0;
      dec_accept <= 1'b0;
    end else begin
      dec_valid  <= last_beat;
      dec_accept <= last_beat && len_ok && hit_any;
    end
  end

  // R8
  short_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (last_beat && !len_ok) |=> (dec_valid && !dec_accept));
  // R9
  accept_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    dec_accept |-> dec_valid);
endmodule

// File: rtl/rx_da_filter.sv
module rx_da_filter
  import rx_filt_pkg::*;
#(
  parameter int MIN_LEN = 12
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic [2:0]  wr_sel,
  input  logic [31:0] wr_data,
  input  logic        in_valid,
  input  logic        in_sop,
  input  logic        in_eop,
  input  logic [7:0]  in_data,
  output logic        dec_valid,
  output logic        dec_accept
);
  filt_cfg_t         cfg_act;
  logic              sop_beat, last_beat, len_ok;
  logic [ADDR_W-1:0] da;
  logic [HASH_W-1:0] hidx;

  rx_filt_cfg u_cfg (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .sop_beat(sop_beat), .act(cfg_act)
  );

  rx_filt_parse #(.MIN_LEN(MIN_LEN)) u_parse (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sop(in_sop), .in_eop(in_eop),
    .in_data(in_data), .sop_beat(sop_beat), .last_beat(last_beat), .len_ok(len_ok),
    .da(da), .hidx(hidx)
  );

  rx_filt_decide u_decide (
    .clk(clk), .rst(rst), .cfg(cfg_act), .last_beat(last_beat), .len_ok(len_ok),
    .da(da), .hidx(hidx), .dec_valid(dec_valid), .dec_accept(dec_accept)
  );

  // R9
  strobe_after_eop_chk: assert property (@(posedge clk) disable iff (rst)
    dec_valid |-> $past(in_valid && in_eop));
  // R11
  idle_no_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !dec_valid);
endmodule

// File: tb/rx_da_filter_tb.sv
module rx_da_filter_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_sel = '0;
  logic [31:0] wr_data = '0;
  logic        in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0;
  logic [7:0]  in_data = '0;
  logic        dec_valid, dec_accept;

  int errs = 0;
  int checks = 0;

  logic [47:0] m_ua0 = '0, m_ua1 = '0;
  logic [63:0] m_gt = '0;
  logic [3:0]  m_ctl = '0;

  always #2 clk = ~clk;

  rx_da_filter u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .in_valid(in_valid), .in_sop(in_sop), .in_eop(in_eop), .in_data(in_data),
    .dec_valid(dec_valid), .dec_accept(dec_accept)
  );

  function automatic logic [5:0] ref_hash(input logic [47:0] d);
    logic [5:0] h = '0;
    for (int s = 0; s < 8; s++) h ^= d[6*s +: 6];
    return h;
  endfunction

  function automatic bit ref_acc(input logic [47:0] d, input int len);
    if (len < 12) return 1'b0;
    return (m_ctl[0] && d == m_ua0) || (m_ctl[1] && d == m_ua1) ||
           (m_ctl[3] && d == 48'hFFFF_FFFF_FFFF) ||
           ((d[0] || m_ctl[2]) && m_gt[ref_hash(d)]);
  endfunction

  // Address whose slice XOR equals k, with the group bit set.
  function automatic logic [47:0] da_for(input logic [5:0] k);
    logic [47:0] d = '0;
    d[5:0] = {k[5:1], 1'b1};
    d[6]   = ~k[0];
    return d;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_wr(input logic [2:0] sel, input logic [31:0] d);
    case (sel)
      3'd0: m_ctl = d[3:0];
      3'd1: m_gt[31:0] = d;
      3'd2: m_gt[63:32] = d;
      3'd3: m_ua0[31:0] = d;
      3'd4: m_ua0[47:32] = d[15:0];
      3'd5: m_ua1[31:0] = d;
      3'd6: m_ua1[47:32] = d[15:0];
      default: ;
    endcase
  endtask

  task automatic cfg_wr(input logic [2:0] sel, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    model_wr(sel, d);
  endtask

  task automatic set_ua0(input logic [47:0] a);
    cfg_wr(3'd3, a[31:0]); cfg_wr(3'd4, {16'h0, a[47:32]});
  endtask
  task automatic set_ua1(input logic [47:0] a);
    cfg_wr(3'd5, a[31:0]); cfg_wr(3'd6, {16'h0, a[47:32]});
  endtask
  task automatic set_tab(input logic [63:0] t);
    cfg_wr(3'd1, t[31:0]); cfg_wr(3'd2, t[63:32]);
  endtask

  task automatic send(input logic [47:0] d, input int len, input bit gap,
                      input int mw_beat, input logic [2:0] mw_sel,
                      input logic [31:0] mw_data, input string req);
    bit exp;
    exp = ref_acc(d, len);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_sop = (i == 0); in_eop = (i == len - 1);
      in_data = (i < 6) ? d[8*i +: 8] : 8'(i * 7 + 3);
      wr_en = (i == mw_beat); wr_sel = mw_sel; wr_data = mw_data;
      if (gap && i == 2 && i != len - 1) begin
        @(negedge clk);
        in_valid = 1'b0; in_sop = 1'b1; in_eop = 1'b1; in_data = 8'hFF; wr_en = 1'b0;
      end
    end
    @(negedge clk);
    in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0; wr_en = 1'b0;
    if (mw_beat >= 0 && mw_beat < len) model_wr(mw_sel, mw_data);
    check({req, " strobe"}, 32'(dec_valid), 32'd1);
    check({req, " accept"}, 32'(dec_accept), 32'(exp));
    @(negedge clk);
    check("R9 strobe one cycle", 32'(dec_valid), 32'd0);
  endtask

  task automatic frame(input logic [47:0] d, input int len, input string req);
    send(d, len, 1'b0, -1, 3'd0, 32'd0, req);
  endtask

  task automatic finish_up;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_up();
  end

  initial begin
    logic [47:0] a0, a1, d;
    logic [63:0] t;
    a0 = 48'hA5_4C_3B_2A_19_02;
    a1 = 48'h70_81_92_A3_B4_C6;
    repeat (4) @(negedge clk);
    check("R1 reset strobe", 32'(dec_valid), 32'd0);
    check("R1 reset accept", 32'(dec_accept), 32'd0);
    rst = 1'b0;
    frame(48'hFFFF_FFFF_FFFF, 16, "R1 unprogrammed drop");
    frame(a0, 16, "R1 unprogrammed drop");

    // R2 R3: byte placement and unicast 0
    set_ua0(a0); cfg_wr(3'd0, 32'h1);
    frame(a0, 20, "R3 ua0 match");
    for (int b = 0; b < 6; b++) frame(a0 ^ (48'h1 << (8 * b + 3)), 20, "R2 byte placement");
    cfg_wr(3'd0, 32'h0);
    frame(a0, 20, "R3 ua0 disabled");

    // R4
    set_ua1(a1); cfg_wr(3'd0, 32'h2);
    frame(a1, 14, "R4 ua1 match");
    frame(a0, 14, "R4 ua0 off");
    cfg_wr(3'd0, 32'h3);
    frame(a0, 14, "R4 both on ua0");
    frame(a1, 14, "R4 both on ua1");

    // R5
    frame(48'hFFFF_FFFF_FFFF, 13, "R5 bcast off");
    cfg_wr(3'd0, 32'h8);
    frame(48'hFFFF_FFFF_FFFF, 13, "R5 bcast on");
    frame(48'hFFFF_FFFF_FFFE, 13, "R5 near bcast");

    // R6: one frame per hash index, one-hot table and its complement
    cfg_wr(3'd0, 32'h0);
    for (int k = 0; k < 64; k++) begin
      set_tab(64'h1 << k);
      frame(da_for(6'(k)), 12, "R6 hash hit");
      set_tab(~(64'h1 << k));
      frame(da_for(6'(k)), 12, "R6 hash miss");
    end
    d = 48'h1234_5678_9ABD;
    t = 64'h0F0F_3C3C_A5A5_6996;
    set_tab(t);
    for (int n = 0; n < 40; n++) begin
      d = d * 48'd25214903917 + 48'd11;
      frame(d, 12 + (n % 5), "R6 mixed");
    end

    // R7
    set_tab('1);
    frame(48'h00_11_22_33_44_56, 15, "R7 individual no hash");
    cfg_wr(3'd0, 32'h4);
    frame(48'h00_11_22_33_44_56, 15, "R7 individual hashed");
    set_tab('0);

    // R8
    cfg_wr(3'd0, 32'h8);
    frame(48'hFFFF_FFFF_FFFF, 11, "R8 len 11");
    frame(48'hFFFF_FFFF_FFFF, 12, "R8 len 12");
    frame(48'hFFFF_FFFF_FFFF, 1, "R8 len 1");
    frame(48'hFFFF_FFFF_FFFF, 6, "R8 len 6");

    // R10
    cfg_wr(3'd0, 32'h1);
    send(a0, 16, 1'b0, 3, 3'd3, 32'h0, "R10 mid-frame write");
    frame(a0, 16, "R10 next frame sees write");
    set_ua0(a0);
    send(a0, 16, 1'b0, 0, 3'd0, 32'h0, "R10 write on start beat");
    frame(a0, 16, "R10 enables cleared");

    // R11
    cfg_wr(3'd0, 32'h1);
    send(a0, 16, 1'b1, -1, 3'd0, 32'h0, "R11 idle gap");
    @(negedge clk);
    in_valid = 1'b1; in_sop = 1'b0; in_eop = 1'b1; in_data = 8'h02;
    @(negedge clk);
    in_valid = 1'b0; in_eop = 1'b0;
    check("R11 stray end beat", 32'(dec_valid), 32'd0);
    frame(a0, 12, "R11 after stray");

    finish_up();
  end
endmodule